// File: doc/BRIEF.md
# Event and cycle performance counters

This block counts hardware activity for software that profiles the surrounding logic. It holds a bank of four 32-bit event counters and one free-running 64-bit cycle counter. Each event counter has a select register that routes one of the event pulse inputs to it. Software reads and writes every register through a simple word-addressed bus: one write strobe, write data and combinational read data.

There are three mask registers: counter enables, overflow flags and interrupt enables. Each has a set address and a clear address, and writing a one to either changes only that bit. Every mask uses one bit layout: bits 0 to 3 are event counters 0 to 3 and bit 31 is the cycle counter. A counter that wraps from all ones to zero raises a sticky overflow flag. The single interrupt line is asserted while any flag is set whose interrupt enable is also set.

The control register holds the global run bit and two one-shot reset bits. Software can write the counters at any time, for example to preload a value near the wrap point.

Top module: `perf_mon`

## Requirements
- R1: After reset every readable register returns zero and `ovf_irq` is low. The counters, selects, masks and control bits are all cleared. Word addresses that are not mapped also read as zero.
- R2: The word addresses are fixed:
  - 0 is control.
  - 1 and 2 are enable set and enable clear.
  - 3 and 4 are interrupt-enable set and clear.
  - 5 and 6 are overflow set and clear.
  - 7 and 8 are the low and high cycle words.
  - 9 to 12 are event counters 0 to 3.
  - 13 to 16 are selects 0 to 3.
- R3: Control bit 0 is the global run bit and reads back as written. Writing a one to control bit 1 clears all event counters on the following clock edge, and writing a one to control bit 2 does the same for the cycle counter. Each reset bit reads as one for exactly one cycle after the write and then returns to zero by itself.
- R4: A write to a set address ORs the written bits into its mask, and a write to a clear address removes them. Zero bits leave the mask unchanged. Both addresses of a pair read back the current mask, with bits 0..3 for event counters, bit 31 for the cycle counter, and all other bits as zero.
- R5: An event counter increases by one on every clock edge at which all three of these hold: the global run bit, its enable bit, and the input selected by its select value. A select value k from 1 to 8 picks event input bit k-1. The select register keeps the low 4 bits of the written data.
- R6: A select value of 0, or any value from 9 to 15, makes its counter hold its value whatever the event inputs do.
- R7: The cycle counter increases by one on every edge at which the run bit and enable bit 31 are set. A carry out of the low word increments the high word in the same edge.
- R8: A bus write to a counter word loads the written data and takes priority over an increment in the same cycle. The following edges count on from the loaded value.
- R9: A counter that increments from all ones to zero sets its overflow flag, and the flag stays set until it is cleared through address 6. Writing ones to address 5 also sets flags. When a wrap and a clear of the same flag happen in the same cycle, the flag stays set.
- R10: `ovf_irq` is high exactly while the AND of the overflow flags and the interrupt enables is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Word address of the register accessed |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_in | input | 8 | Event pulses from the surrounding logic |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The hardest situations to reach from the ports are the wrap points. Counting 2^32 or 2^64 events is out of reach, so the stimulus first preloads the counters to a few counts below all ones. It then runs a known number of enabled edges and checks the wrapped value, the carry into the high cycle word and the sticky flag. A sweep over every select value drives a computed event pattern for a fixed window, and the bench compares each count with the number of high cycles on the selected input. The bench also checks that an increment in the same cycle as a bus write is lost to the write.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;

    localparam int PM_DATA_W  = 32;
    localparam int PM_ADDR_W  = 5;
    localparam int PM_NUM_CNT = 4;
    localparam int PM_CYC_BIT = 31;
    localparam int PM_CYC_W   = 2 * PM_DATA_W;

    typedef logic [PM_ADDR_W-1:0] pm_addr_t;
    typedef logic [PM_DATA_W-1:0] pm_word_t;

    // word addresses
    localparam int PM_A_CTRL    = 0;
    localparam int PM_A_EN_SET  = 1;
    localparam int PM_A_EN_CLR  = 2;
    localparam int PM_A_IRQ_SET = 3;
    localparam int PM_A_IRQ_CLR = 4;
    localparam int PM_A_OVF_SET = 5;
    localparam int PM_A_OVF_CLR = 6;
    localparam int PM_A_CYC_LO  = 7;
    localparam int PM_A_CYC_HI  = 8;
    localparam int PM_A_CNT0    = 9;
    localparam int PM_A_SEL0    = PM_A_CNT0 + PM_NUM_CNT;

    // one bit per event counter plus one for the cycle counter
    typedef struct packed {
        logic                  cyc;
        logic [PM_NUM_CNT-1:0] evt;
    } pm_mask_t;

    localparam int PM_MASK_W = $bits(pm_mask_t);

    // bit order matches the control word: [2]=cycle reset [1]=event reset [0]=run
    typedef struct packed {
        logic cyc_rst;
        logic evt_rst;
        logic run;
    } pm_ctrl_t;

    function automatic pm_word_t mask_to_word(pm_mask_t m);
        pm_word_t w;
        w = '0;
        w[PM_CYC_BIT]     = m.cyc;
        w[PM_NUM_CNT-1:0] = m.evt;
        return w;
    endfunction

    function automatic pm_word_t ctrl_to_word(pm_ctrl_t c);
        pm_word_t w;
        w = '0;
        w[$bits(pm_ctrl_t)-1:0] = c;
        return w;
    endfunction

    function automatic logic addr_is(pm_addr_t a, int idx);
        return a == pm_addr_t'(idx);
    endfunction

endpackage

// File: rtl/perf_mon_mask_pair.sv
module perf_mon_mask_pair
    import perf_mon_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     set_wr,
    input  logic     clr_wr,
    input  pm_mask_t wmask,
    input  pm_mask_t hw_set,
    output pm_mask_t mask
);
    logic [PM_MASK_W-1:0] mask_q;
    logic [PM_MASK_W-1:0] mask_d;

    always_comb begin
        mask_d = mask_q;
        if (set_wr) mask_d = mask_d | wmask;
        if (clr_wr) mask_d = mask_d & ~wmask;
        // a hardware set in the same cycle as a clear is kept
        mask_d = mask_d | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_d;
    end

    assign mask = pm_mask_t'(mask_q);

    AST_HWSET_STICKS: assert property (@(posedge clk) disable iff (rst)
        (|hw_set) |=> ((mask & $past(hw_set)) == $past(hw_set))); // R9

    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!set_wr && !clr_wr && hw_set == '0) |=> $stable(mask)); // R4

endmodule

// File: rtl/perf_mon_evt_cnt.sv
module perf_mon_evt_cnt
    import perf_mon_pkg::*;
#(
    parameter int NUM_EVT = 8,
    parameter int SEL_W   = $clog2(NUM_EVT + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               clr,
    input  logic               cnt_wr,
    input  logic               sel_wr,
    input  pm_word_t           wdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output pm_word_t           count,
    output logic [SEL_W-1:0]   sel,
    output logic               wrap
);
    pm_word_t         cnt_q;
    logic [SEL_W-1:0] sel_q;
    logic             hit;
    logic             inc;

    // select 0 and values above NUM_EVT match no input
    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < NUM_EVT; k++) begin
            if (sel_q == SEL_W'(k + 1)) hit = evt_in[k];
        end
    end

    assign inc  = run & hit;
    assign wrap = inc & ~cnt_wr & ~clr & (&cnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sel_q <= '0;
        end else begin
            if (sel_wr) sel_q <= wdata[SEL_W-1:0];
            if (clr)         cnt_q <= '0;
            else if (cnt_wr) cnt_q <= wdata;
            else if (inc)    cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;
    assign sel   = sel_q;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr && !clr) |=> $stable(count)); // R5

    AST_NULL_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sel == '0 && !sel_wr && !cnt_wr && !clr) |=> $stable(count)); // R6

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (count == '0)); // R9

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && !clr) |=> (count == $past(wdata))); // R8

endmodule

// File: rtl/perf_mon_cyc_cnt.sv
module perf_mon_cyc_cnt
    import perf_mon_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                clr,
    input  logic                lo_wr,
    input  logic                hi_wr,
    input  pm_word_t            wdata,
    output logic [PM_CYC_W-1:0] count,
    output logic                wrap
);
    logic [PM_CYC_W-1:0] cnt_q;
    logic [PM_CYC_W-1:0] cnt_d;

    always_comb begin
        cnt_d = run ? cnt_q + 1'b1 : cnt_q;
        if (lo_wr) cnt_d[PM_DATA_W-1:0]        = wdata;
        if (hi_wr) cnt_d[PM_CYC_W-1:PM_DATA_W] = wdata;
        if (clr)   cnt_d = '0;
    end

    assign wrap = run & ~clr & ~lo_wr & ~hi_wr & (&cnt_q);

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    AST_CYC_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && !clr && !lo_wr && !hi_wr) |=> (count == $past(count) + 1'b1)); // R7

    AST_CYC_CLR: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0)); // R3

endmodule

// File: rtl/perf_mon.sv
module perf_mon
    import perf_mon_pkg::*;
#(
    parameter int NUM_EVT = 8,
    localparam int SEL_W  = $clog2(NUM_EVT + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PM_ADDR_W-1:0] bus_addr,
    input  logic                 bus_wr,
    input  logic [PM_DATA_W-1:0] bus_wdata,
    output logic [PM_DATA_W-1:0] bus_rdata,
    input  logic [NUM_EVT-1:0]   evt_in,
    output logic                 ovf_irq
);
    pm_ctrl_t            ctrl_q;
    pm_mask_t            wmask;
    pm_mask_t            en_mask, irq_mask, ovf_mask, wrap_mask;
    logic                ctrl_wr;
    logic [PM_NUM_CNT-1:0] evt_wrap;
    logic                cyc_wrap;
    logic [PM_CYC_W-1:0] cyc_cnt;
    pm_word_t            cnt_q [PM_NUM_CNT];
    logic [SEL_W-1:0]    sel_q [PM_NUM_CNT];

    assign wmask   = '{cyc: bus_wdata[PM_CYC_BIT], evt: bus_wdata[PM_NUM_CNT-1:0]};
    assign ctrl_wr = bus_wr & addr_is(bus_addr, PM_A_CTRL);

    // control: run bit is held, reset bits are one-shot
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q.run <= bus_wdata[0];
            ctrl_q.evt_rst <= ctrl_wr & bus_wdata[1];
            ctrl_q.cyc_rst <= ctrl_wr & bus_wdata[2];
        end
    end

    perf_mon_mask_pair u_en (
        .clk(clk), .rst(rst),
        .set_wr(bus_wr & addr_is(bus_addr, PM_A_EN_SET)),
        .clr_wr(bus_wr & addr_is(bus_addr, PM_A_EN_CLR)),
        .wmask(wmask), .hw_set('0), .mask(en_mask)
    );

    perf_mon_mask_pair u_irq (
        .clk(clk), .rst(rst),
        .set_wr(bus_wr & addr_is(bus_addr, PM_A_IRQ_SET)),
        .clr_wr(bus_wr & addr_is(bus_addr, PM_A_IRQ_CLR)),
        .wmask(wmask), .hw_set('0), .mask(irq_mask)
    );

    assign wrap_mask = '{cyc: cyc_wrap, evt: evt_wrap};

    perf_mon_mask_pair u_ovf (
        .clk(clk), .rst(rst),
        .set_wr(bus_wr & addr_is(bus_addr, PM_A_OVF_SET)),
        .clr_wr(bus_wr & addr_is(bus_addr, PM_A_OVF_CLR)),
        .wmask(wmask), .hw_set(wrap_mask), .mask(ovf_mask)
    );

    for (genvar i = 0; i < PM_NUM_CNT; i++) begin : g_evt
        perf_mon_evt_cnt #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_cnt (
            .clk(clk), .rst(rst),
            .run(ctrl_q.run & en_mask.evt[i]),
            .clr(ctrl_q.evt_rst),
            .cnt_wr(bus_wr & addr_is(bus_addr, PM_A_CNT0 + i)),
            .sel_wr(bus_wr & addr_is(bus_addr, PM_A_SEL0 + i)),
            .wdata(bus_wdata),
            .evt_in(evt_in),
            .count(cnt_q[i]),
            .sel(sel_q[i]),
            .wrap(evt_wrap[i])
        );
    end

    perf_mon_cyc_cnt u_cyc (
        .clk(clk), .rst(rst),
        .run(ctrl_q.run & en_mask.cyc),
        .clr(ctrl_q.cyc_rst),
        .lo_wr(bus_wr & addr_is(bus_addr, PM_A_CYC_LO)),
        .hi_wr(bus_wr & addr_is(bus_addr, PM_A_CYC_HI)),
        .wdata(bus_wdata),
        .count(cyc_cnt),
        .wrap(cyc_wrap)
    );

    always_comb begin
        bus_rdata = '0;
        if (addr_is(bus_addr, PM_A_CTRL))
            bus_rdata = ctrl_to_word(ctrl_q);
        if (addr_is(bus_addr, PM_A_EN_SET) || addr_is(bus_addr, PM_A_EN_CLR))
            bus_rdata = mask_to_word(en_mask);
        if (addr_is(bus_addr, PM_A_IRQ_SET) || addr_is(bus_addr, PM_A_IRQ_CLR))
            bus_rdata = mask_to_word(irq_mask);
        if (addr_is(bus_addr, PM_A_OVF_SET) || addr_is(bus_addr, PM_A_OVF_CLR))
            bus_rdata = mask_to_word(ovf_mask);
        if (addr_is(bus_addr, PM_A_CYC_LO))
            bus_rdata = cyc_cnt[PM_DATA_W-1:0];
        if (addr_is(bus_addr, PM_A_CYC_HI))
            bus_rdata = cyc_cnt[PM_CYC_W-1:PM_DATA_W];
        for (int i = 0; i < PM_NUM_CNT; i++) begin
            if (addr_is(bus_addr, PM_A_CNT0 + i)) bus_rdata = cnt_q[i];
            if (addr_is(bus_addr, PM_A_SEL0 + i)) bus_rdata[SEL_W-1:0] = sel_q[i];
        end
    end

    assign ovf_irq = |(ovf_mask & irq_mask);

    AST_RST_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.evt_rst && !(ctrl_wr && bus_wdata[1])) |=> !ctrl_q.evt_rst); // R3

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        ovf_irq |-> (irq_mask != '0)); // R10

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        ovf_irq |-> (ovf_mask != '0)); // R10

endmodule

// File: tb/perf_mon_tb.sv
`timescale 1ns/1ps
module perf_mon_tb;
    localparam int A_CTRL = 0, A_ENS = 1, A_ENC = 2, A_IRQS = 3, A_IRQC = 4;
    localparam int A_OVFS = 5, A_OVFC = 6, A_CLO = 7, A_CHI = 8, A_CNT = 9, A_SEL = 13;
    localparam int WIN = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  evt_in = '0;
    logic        ovf_irq;

    int n_chk = 0;
    int n_bad = 0;

    perf_mon u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .ovf_irq(ovf_irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 5'(a); bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 5'(a);
        #1 d = bus_rdata;
    endtask

    function automatic logic [7:0] pat(input int c, input int s);
        return 8'((c * 37 + s * 11) ^ (c >> 1));
    endfunction

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state, every address including unmapped ones
        for (int a = 0; a < 20; a++) begin
            rd(a, v);
            chk($sformatf("R1 addr %0d", a), v, 32'h0);
        end
        chk("R1 irq", {31'b0, ovf_irq}, 32'h0);

        // R4: set/clear masks
        wr(A_ENS, 32'hFFFF_FFFF);
        rd(A_ENS, v); chk("R4 enable set read", v, 32'h8000_000F);
        wr(A_ENC, 32'h8000_0005);
        rd(A_ENC, v); chk("R4 enable via clear addr", v, 32'h0000_000A);
        wr(A_ENS, 32'h0000_0000);
        rd(A_ENS, v); chk("R4 zero write no effect", v, 32'h0000_000A);
        wr(A_ENS, 32'h0000_000F);

        // R5 R6: sweep of every select value, R2 addresses of counters/selects
        for (int s = 0; s < 16; s++) begin
            int j;
            int exp;
            j = s % 4;
            exp = 0;
            wr(A_CTRL, 32'h2);
            wr(A_SEL + j, 32'(s));
            rd(A_SEL + j, v); chk($sformatf("R2 select %0d readback", j), v, 32'(s));
            wr(A_CTRL, 32'h1);
            for (int c = 0; c < WIN; c++) begin
                @(negedge clk) evt_in = pat(c, s);
                if (s >= 1 && s <= 8 && pat(c, s)[s-1]) exp++;
                @(posedge clk);
            end
            @(negedge clk) evt_in = '0;
            wr(A_CTRL, 32'h0);
            rd(A_CNT + j, v);
            chk($sformatf("%s sel %0d counter %0d", (s >= 1 && s <= 8) ? "R5" : "R6", s, j),
                v, 32'(exp));
        end

        // R5: own enable bit clear stops counting
        wr(A_CTRL, 32'h2);
        wr(A_SEL, 32'd1);
        wr(A_ENC, 32'h1);
        wr(A_CTRL, 32'h1);
        @(negedge clk) evt_in = 8'h01;
        repeat (5) @(posedge clk);
        @(negedge clk) evt_in = '0;
        wr(A_CTRL, 32'h0);
        rd(A_CNT, v); chk("R5 disabled counter holds", v, 32'h0);
        wr(A_ENS, 32'h1);

        // R3: reset bits one-shot
        wr(A_CNT + 2, 32'h1234);
        wr(A_CTRL, 32'h3);
        rd(A_CTRL, v); chk("R3 reset bit visible", v, 32'h3);
        @(posedge clk);
        rd(A_CTRL, v); chk("R3 reset bit self-clears", v, 32'h1);
        rd(A_CNT + 2, v); chk("R3 event counters cleared", v, 32'h0);
        wr(A_CTRL, 32'h0);

        // R8: write wins over increment
        @(negedge clk) evt_in = 8'h01;
        wr(A_CTRL, 32'h1);
        wr(A_CNT, 32'd100);
        rd(A_CNT, v); chk("R8 write beats increment", v, 32'd100);
        @(posedge clk);
        rd(A_CNT, v); chk("R8 counts on from written value", v, 32'd101);

        // R9: event counter wrap
        wr(A_CNT, 32'hFFFF_FFFE);
        repeat (2) @(posedge clk);
        @(negedge clk) evt_in = '0;
        wr(A_CTRL, 32'h0);
        rd(A_CNT, v); chk("R9 wrapped to zero", v, 32'h0);
        rd(A_OVFS, v); chk("R9 flag set by wrap", v, 32'h1);

        // R10: interrupt gating
        chk("R10 irq low without enable", {31'b0, ovf_irq}, 32'h0);
        wr(A_IRQS, 32'h1);
        rd(A_IRQS, v); chk("R4 irq enable readback", v, 32'h1);
        chk("R10 irq high", {31'b0, ovf_irq}, 32'h1);
        wr(A_OVFC, 32'h1);
        rd(A_OVFS, v); chk("R9 flag cleared", v, 32'h0);
        chk("R10 irq low after clear", {31'b0, ovf_irq}, 32'h0);
        wr(A_OVFS, 32'h8000_0000);
        rd(A_OVFC, v); chk("R9 flag set by write", v, 32'h8000_0000);
        chk("R10 irq low flag not enabled", {31'b0, ovf_irq}, 32'h0);
        wr(A_OVFC, 32'h8000_0000);

        // R7: cycle counter carry
        wr(A_ENC, 32'h0000_000F);
        wr(A_ENS, 32'h8000_0000);
        wr(A_CLO, 32'hFFFF_FFFF);
        wr(A_CHI, 32'h0000_0005);
        wr(A_CTRL, 32'h1);
        wr(A_CTRL, 32'h0);
        rd(A_CLO, v); chk("R7 low word after carry", v, 32'h0);
        rd(A_CHI, v); chk("R7 high word after carry", v, 32'h6);

        // R7 R9: 64-bit wrap, K=2 extra edges -> 3 increments
        wr(A_CLO, 32'hFFFF_FFFE);
        wr(A_CHI, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h1);
        repeat (2) @(posedge clk);
        wr(A_CTRL, 32'h0);
        rd(A_CLO, v); chk("R7 low word after wrap", v, 32'h1);
        rd(A_CHI, v); chk("R7 high word after wrap", v, 32'h0);
        rd(A_OVFS, v); chk("R9 cycle flag", v, 32'h8000_0000);

        // R3: cycle reset bit
        wr(A_CTRL, 32'h4);
        @(posedge clk);
        rd(A_CLO, v); chk("R3 cycle counter cleared", v, 32'h0);

        finish_run();
    end
endmodule